// File: doc/BRIEF.md
# End-of-Write Status Read Path

This block is the read side of a paged non-volatile memory. It qualifies read accesses from the synchronized chip-enable, output-enable and write-enable strobes and forwards the address to the array read port. It then returns one byte and an enable for the external tristate driver. While the write controller reports programming in progress, the block does not touch the array. A read then returns a status word: the top bit is the inverse of the top bit of the last byte written, and the next bit flips on every new read access. Once programming is over, reads return true array data again.

Software can poll either status bit from the moment a write starts. A driver can watch the inverted top bit until it matches the written value, or read twice and compare the flipping bit. All outputs are registered, so a read presented in one cycle appears on the outputs after the next rising clock edge.

Top module: `rbk_status_readback`

## Requirements
- R1: A read is qualified when chip-enable and output-enable are low (0) and write-enable is high (1). One cycle after a qualified cycle, dout_oe is 1. After any other cycle, dout_oe is 0 and dout is all zeros.
- R2: When not busy, a qualified read returns the array data for the presented address one cycle later. arr_addr always equals addr, and the array is read combinationally.
- R3: During a qualified read while busy, output bit 7 is the inverse of bit 7 of last_byte.
- R4: During a qualified read while busy, output bits 5..0 equal bits 5..0 of last_byte.
- R5: Output bit 6 is 0 on the first read access that starts after busy rises. It alternates on each later access that starts while busy. It starts again at 0 for every new programming cycle, whatever value it had before.
- R6: An access counts once, when the qualify condition goes from false to true. While an access is held and busy stays high, bit 6 does not change.
- R7: A new access may be started by raising and lowering output-enable alone, chip-enable alone, or write-enable (high, low, then high again). Each of these advances bit 6.
- R8: When busy falls during a held read, the output returns true array data on the next cycle, with no new access needed.
- R9: When busy rises in the same cycle that an access starts, that access returns bit 6 as 0, and the next access returns 1.
- R10: arr_rd_en is 1 exactly when the current cycle is qualified and busy is 0, so the array is never read during programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Synchronized chip-enable, active low |
| oe_n | input | 1 | Synchronized output-enable, active low |
| we_n | input | 1 | Synchronized write-enable, active low |
| addr | input | 15 | Read address |
| busy | input | 1 | Programming in progress, from the write controller |
| last_byte | input | 8 | Last byte loaded by the write controller |
| arr_rdata | input | 8 | Combinational array read data |
| arr_addr | output | 15 | Address forwarded to the array read port |
| arr_rd_en | output | 1 | Array read strobe |
| dout | output | 8 | Read data or status word |
| dout_oe | output | 1 | Enable for the external tristate driver |

## Verification
Two events can land in the same clock cycle: the start of programming (busy rising) and the start of a read access. The start of programming clears the flipping bit, and the start of a read samples it and then flips it. The bench raises busy in exactly the cycle where chip-enable, output-enable and write-enable first qualify a read. It expects bit 6 to be 0 on that access and 1 on the next one. A second overlap is busy falling while a read is held: the bench expects array data in the very next cycle.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
  typedef struct packed {
    logic qual;       // read qualified this cycle
    logic start;      // qualify condition just became true
    logic busy;       // programming in progress this cycle
    logic busy_rise;  // programming began this cycle
  } rbk_evt_t;

  function automatic int stat_inv_bit(input int data_w);
    return data_w - 1;
  endfunction

  function automatic int stat_tog_bit(input int data_w);
    return data_w - 2;
  endfunction
endpackage

// File: rtl/rbk_rst_sync.sv
module rbk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/rbk_access_detect.sv
module rbk_access_detect
  import rbk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ce_n,
  input  logic     oe_n,
  input  logic     we_n,
  input  logic     busy,
  output rbk_evt_t evt
);
  logic qual_c;
  logic qual_q, qual_d;
  logic busy_q, busy_d;

  always_comb begin
    qual_c        = ~ce_n & ~oe_n & we_n;
    qual_d        = qual_c;
    busy_d        = busy;
    evt.qual      = qual_c;
    evt.start     = qual_c & ~qual_q;
    evt.busy      = busy;
    evt.busy_rise = busy & ~busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      qual_q <= qual_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/rbk_toggle_track.sv
module rbk_toggle_track
  import rbk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  rbk_evt_t evt,
  output logic     tog_shown
);
  logic tog_q, tog_d, tog_en;
  logic held_q, held_d, held_en;
  logic tog_base;
  logic busy_start;

  always_comb begin
    busy_start = evt.start & evt.busy;
    tog_base   = evt.busy_rise ? 1'b0 : tog_q;
    tog_en     = busy_start | evt.busy_rise;
    tog_d      = busy_start ? ~tog_base : 1'b0;
    held_en    = busy_start;
    held_d     = tog_base;
    tog_shown  = busy_start ? tog_base : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q  <= 1'b0;
      held_q <= 1'b0;
    end else begin
      if (tog_en)  tog_q  <= tog_d;
      if (held_en) held_q <= held_d;
    end
  end
endmodule

// File: rtl/rbk_out_stage.sv
module rbk_out_stage
  import rbk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rbk_evt_t          evt,
  input  logic              tog_shown,
  input  logic [DATA_W-1:0] last_byte,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  localparam int INV_B = stat_inv_bit(DATA_W);
  localparam int TOG_B = stat_tog_bit(DATA_W);

  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] dout_d;
  logic              oe_d;
  logic              dout_en;

  for (genvar b = 0; b < DATA_W; b++) begin : g_lane
    if (b == INV_B) begin : g_inv
      assign stat_word[b] = ~last_byte[b];
    end else if (b == TOG_B) begin : g_tog
      assign stat_word[b] = tog_shown;
    end else begin : g_pass
      assign stat_word[b] = last_byte[b];
    end
  end

  always_comb begin
    oe_d    = evt.qual;
    dout_en = evt.qual | dout_oe;
    if (!evt.qual)    dout_d = '0;
    else if (evt.busy) dout_d = stat_word;
    else              dout_d = arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      if (dout_en) dout <= dout_d;
      dout_oe <= oe_d;
    end
  end
endmodule

// File: rtl/rbk_status_readback.sv
module rbk_status_readback
  import rbk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  input  logic [DATA_W-1:0] last_byte,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_rd_en,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  logic     rst_n_s;
  rbk_evt_t evt;
  logic     tog_shown;

  rbk_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  rbk_access_detect u_det (
    .clk   (clk),
    .rst_n (rst_n_s),
    .ce_n  (ce_n),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .busy  (busy),
    .evt   (evt)
  );

  rbk_toggle_track u_tog (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .evt       (evt),
    .tog_shown (tog_shown)
  );

  rbk_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .evt       (evt),
    .tog_shown (tog_shown),
    .last_byte (last_byte),
    .arr_rdata (arr_rdata),
    .dout      (dout),
    .dout_oe   (dout_oe)
  );

  assign arr_addr  = addr;
  assign arr_rd_en = evt.qual & ~evt.busy;
endmodule

// File: rtl/rbk_status_readback_chk.sv
module rbk_status_readback_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              busy,
  input logic [DATA_W-1:0] last_byte,
  input logic              arr_rd_en,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe
);
  logic rq;
  assign rq = ~ce_n & ~oe_n & we_n;

  assert_oe_follows_qual_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> $past(rq));

  assert_idle_bus_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == '0));

  assert_poll_inverted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(busy)) |-> (dout[DATA_W-1] == ~$past(last_byte[DATA_W-1])));

  assert_status_low_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(busy)) |-> (dout[DATA_W-3:0] == $past(last_byte[DATA_W-3:0])));

  assert_held_toggle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rq) && $past(rq, 2) && $past(busy) && $past(busy, 2))
      |-> $stable(dout[DATA_W-2]));

  assert_no_array_read_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !arr_rd_en);
endmodule

bind rbk_status_readback rbk_status_readback_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .busy      (busy),
  .last_byte (last_byte),
  .arr_rd_en (arr_rd_en),
  .dout      (dout),
  .dout_oe   (dout_oe)
);

// File: tb/sim_rbk_status_readback.sv
module sim_rbk_status_readback;
  localparam int DW = 8;
  localparam int AW = 15;

  typedef struct {
    logic          oe;
    logic [DW-1:0] d;
    logic          en;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          busy = 1'b0;
  logic [DW-1:0] last_byte = '0;
  logic [DW-1:0] arr_rdata;
  logic [AW-1:0] arr_addr;
  logic          arr_rd_en;
  logic [DW-1:0] dout;
  logic          dout_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  assign arr_rdata = arr_addr[DW-1:0] ^ 8'h5A;

  rbk_status_readback u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .busy(busy), .last_byte(last_byte), .arr_rdata(arr_rdata),
    .arr_addr(arr_addr), .arr_rd_en(arr_rd_en), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic step(input logic c, input logic o, input logic w, input logic b,
                      input logic [AW-1:0] a, input logic [DW-1:0] lb,
                      input logic eo, input logic [DW-1:0] ed, input string req);
    exp_t e;
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; busy = b; addr = a; last_byte = lb;
    e.oe = eo; e.d = ed; e.req = req;
    e.en = ~c & ~o & w & ~b;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (dout_oe !== e.oe || dout !== e.d) begin
        errors++;
        $display("FAIL %s: oe=%0b dout=%02h expected oe=%0b dout=%02h", e.req, dout_oe, dout, e.oe, e.d);
      end
      checks++;
      if (arr_rd_en !== e.en) begin
        errors++;
        $display("FAIL R10: arr_rd_en=%0b expected %0b (%s)", arr_rd_en, e.en, e.req);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (dout_oe !== 1'b0 || dout !== 8'h00) begin
      errors++;
      $display("FAIL R1: reset oe=%0b dout=%02h expected oe=0 dout=00", dout_oe, dout);
    end
    // R1 / R2: plain reads and non-qualifying strobe mixes
    step(1,0,1,0,15'h0123,8'h00, 0,8'h00,"R1");
    step(0,0,1,0,15'h0123,8'h00, 1,8'h79,"R2");
    step(0,1,1,0,15'h0123,8'h00, 0,8'h00,"R1");
    step(0,0,0,0,15'h0123,8'h00, 0,8'h00,"R1");
    step(0,0,1,0,15'h00FF,8'h00, 1,8'hA5,"R2");
    // programming with last byte C3: status 03 / 43
    step(0,1,1,1,15'h00AA,8'hC3, 0,8'h00,"R10");
    step(0,0,1,1,15'h00AA,8'hC3, 1,8'h03,"R3 R4 R5");
    step(0,0,1,1,15'h00AA,8'hC3, 1,8'h03,"R6");
    step(0,1,1,1,15'h00AA,8'hC3, 0,8'h00,"R1");
    step(0,0,1,1,15'h00AA,8'hC3, 1,8'h43,"R7 oe");
    step(1,0,1,1,15'h00AA,8'hC3, 0,8'h00,"R1");
    step(0,0,1,1,15'h00AA,8'hC3, 1,8'h03,"R7 ce");
    step(0,0,0,1,15'h00AA,8'hC3, 0,8'h00,"R1");
    step(0,0,1,1,15'h00AA,8'hC3, 1,8'h43,"R7 we");
    step(0,0,1,0,15'h00AA,8'hC3, 1,8'hF0,"R8");
    step(1,1,1,0,15'h00AA,8'hC3, 0,8'h00,"R1");
    // busy rises on the access start cycle, last byte 2C: status AC / EC
    step(0,0,1,1,15'h0055,8'h2C, 1,8'hAC,"R9");
    step(0,1,1,1,15'h0055,8'h2C, 0,8'h00,"R1");
    step(0,0,1,1,15'h0055,8'h2C, 1,8'hEC,"R9");
    step(0,1,1,1,15'h0055,8'h2C, 0,8'h00,"R1");
    step(0,0,1,1,15'h0055,8'h2C, 1,8'hAC,"R5");
    step(0,1,1,0,15'h0055,8'h2C, 0,8'h00,"R1");
    // new programming cycle while toggle state is 1: restarts at 0
    step(0,1,1,1,15'h0055,8'hC3, 0,8'h00,"R10");
    step(0,0,1,1,15'h0055,8'hC3, 1,8'h03,"R5 restart");
    step(0,1,1,0,15'h0055,8'hC3, 0,8'h00,"R1");
    step(0,0,1,0,15'h0055,8'hC3, 1,8'h0F,"R2");
    step(1,1,1,0,15'h0055,8'hC3, 0,8'h00,"R1");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule